// File: doc/BRIEF.md
# Display Serial Command/Parameter Monitor

This block listens, without driving anything, to the four-wire serial link between a host and a display controller. The four wires are an active-low select, a serial clock, a serial data line and a data/command line. All four are brought into the system clock domain and the serial clock is oversampled. Bits are gathered MSB-first into bytes. The level of the data/command line at the end of each byte tags that byte as a command opcode or as a parameter.

A two-state machine turns the byte stream into records. In `FR_IDLE` no command is open. A command byte takes the *open* transition to `FR_OPEN`, and a parameter byte takes the *orphan drop* transition, which stays in `FR_IDLE`. In `FR_OPEN`, a parameter byte takes the *append* transition, which stays in `FR_OPEN`. A new command byte takes the *chain* transition: it emits the current record and opens a new one, staying in `FR_OPEN`. A rising select takes the *close* transition back to `FR_IDLE` and emits the record.

Each emitted record is a one-cycle strobe. It carries the opcode, the stored parameter count, up to sixteen parameter bytes, a truncation flag and an unknown-opcode flag. The block is meant for bus tracing and for protocol checking in a chip that talks to a panel. The system clock must run at least four times faster than the serial clock.

Top module: `disp_spi_mon`

## Requirements
- R1: While `spi_csn` is high, clock and data activity has no effect: no record and no orphan pulse appears, and the next selected byte assembles from a fresh bit count.
- R2: A data bit is captured at a rising serial clock edge and committed at the next falling edge. A falling edge with no capture since the last commit is ignored.
- R3: Bytes are assembled MSB-first from eight committed bits. The bit count restarts after every eighth bit.
- R4: `spi_dcx` is sampled when the eighth bit commits. Low (0) marks an opcode and high (1) marks a parameter byte.
- R5: A command byte that arrives while a record is open emits that record first. The new opcode then starts a fresh record with count 0, cleared parameters and cleared flags.
- R6: Parameter byte number i (from 0) is placed at `rec_params[8i+7:8i]` while the stored count is below MAX_PARAMS (16). Later bytes are not stored and set `rec_trunc`. Slots beyond the count read 0.
- R7: `rec_unknown` is 1 exactly when the opcode lies outside the supported set: 0x00, 0x01, 0x04, 0x09, 0x10 to 0x13, 0x20, 0x21, 0x28, 0x29, 0x2A, 0x2B, 0x2C, 0x2E, 0x30, 0x36, 0x3A, 0xB1 to 0xB4, 0xB6, 0xC0 to 0xC5, 0xDA to 0xDD, 0xE0, 0xE1 and 0xFC.
- R8: A parameter byte that arrives with no open command since select fell is dropped and raises `orphan_pulse` for one cycle.
- R9: A rising select discards any partial byte and emits the open record, if there is one.
- R10: Synchronous active-high `rst` clears all outputs, counters, flags and the open record. A record that was open before reset is never emitted.
- R11: `rec_valid` is a single-cycle strobe and never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_csn | input | 1 | Link select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data from host |
| spi_dcx | input | 1 | Data (1) / command (0) select |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_opcode | output | 8 | Opcode of the record |
| rec_count | output | 5 | Number of stored parameter bytes |
| rec_params | output | 128 | Parameter bytes, byte i at bits 8i+7:8i |
| rec_trunc | output | 1 | More parameters arrived than were stored |
| rec_unknown | output | 1 | Opcode outside the supported set |
| orphan_pulse | output | 1 | A parameter byte was dropped with no open command |

## Verification
A bit counter that is off by one shows up as a shifted opcode or shifted parameter value in the very next record, one byte time later. A leftover captured bit or an unsynchronised select shows up the same way after a deselect. If the record state machine is in the wrong state, records go missing or extra ones appear: an emission is lost at select rise, or an orphan pulse fires where a parameter should have been appended. Both are visible within a few system cycles of the byte that exposes them. Truncation and unknown-flag errors appear in the first record whose length or opcode crosses the boundary.

// File: rtl/dspim_pkg.sv
`timescale 1ns/1ps
package dspim_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BCNT_W    = $clog2(BYTE_BITS);

    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_OPEN = 1'b1
    } fr_state_t;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            8'h00, 8'h01, 8'h04, 8'h09,
            8'h10, 8'h11, 8'h12, 8'h13,
            8'h20, 8'h21, 8'h28, 8'h29,
            8'h2A, 8'h2B, 8'h2C, 8'h2E,
            8'h30, 8'h36, 8'h3A,
            8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB6,
            8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5,
            8'hDA, 8'hDB, 8'hDC, 8'hDD,
            8'hE0, 8'hE1, 8'hFC: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dspim_sync.sv
`timescale 1ns/1ps
module dspim_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dspim_deser.sv
`timescale 1ns/1ps
module dspim_deser
    import dspim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       s_csn,
    input  logic       s_sck,
    input  logic       s_sdi,
    input  logic       s_dcx,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_param,
    output logic       cs_end
);

    logic              sck_prev, csn_prev;
    logic              held_bit, have_bit;
    logic [BCNT_W-1:0] bit_cnt;
    logic [BYTE_BITS-2:0] shreg;
    logic              sck_rise, sck_fall;

    assign sck_rise = s_sck & ~sck_prev;
    assign sck_fall = ~s_sck & sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev   <= 1'b0;
            csn_prev   <= 1'b1;
            held_bit   <= 1'b0;
            have_bit   <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_param <= 1'b0;
            cs_end     <= 1'b0;
        end else begin
            sck_prev   <= s_sck;
            csn_prev   <= s_csn;
            byte_valid <= 1'b0;
            cs_end     <= s_csn & ~csn_prev;
            if (s_csn) begin
                have_bit <= 1'b0;
                bit_cnt  <= '0;
            end else if (sck_rise) begin
                held_bit <= s_sdi;
                have_bit <= 1'b1;
            end else if (sck_fall && have_bit) begin
                have_bit <= 1'b0;
                shreg    <= {shreg[BYTE_BITS-3:0], held_bit};
                if (bit_cnt == BCNT_W'(BYTE_BITS-1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= {shreg, held_bit};
                    byte_param <= s_dcx;
                    bit_cnt    <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        s_csn |=> !byte_valid);
    a_r3_byte_spacing: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);
    a_r2_commit_needs_capture: assert property (@(posedge clk) disable iff (rst)
        (sck_fall && !have_bit) |=> $stable(bit_cnt));

endmodule

// File: rtl/dspim_framer.sv
`timescale 1ns/1ps
module dspim_framer
    import dspim_pkg::*;
#(
    parameter int MAX_PARAMS = 16,
    localparam int CW = $clog2(MAX_PARAMS + 1),
    localparam int PW = MAX_PARAMS * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          byte_param,
    input  logic          cs_end,
    output logic          rec_valid,
    output logic [7:0]    rec_opcode,
    output logic [CW-1:0] rec_count,
    output logic [PW-1:0] rec_params,
    output logic          rec_trunc,
    output logic          rec_unknown,
    output logic          orphan_pulse
);

    fr_state_t     state_q, state_d;
    logic [7:0]    op_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] par_q;
    logic          trunc_q, unk_q;
    logic          is_cmd, is_par, emit;

    assign is_cmd = byte_valid && !byte_param;
    assign is_par = byte_valid &&  byte_param;
    assign emit   = (state_q == FR_OPEN) && (is_cmd || cs_end);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: if (is_cmd) state_d = FR_OPEN;
            FR_OPEN: if (cs_end) state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FR_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0; cnt_q <= '0; par_q <= '0; trunc_q <= 1'b0; unk_q <= 1'b0;
            rec_valid <= 1'b0; rec_opcode <= '0; rec_count <= '0; rec_params <= '0;
            rec_trunc <= 1'b0; rec_unknown <= 1'b0; orphan_pulse <= 1'b0;
        end else begin
            rec_valid    <= emit;
            orphan_pulse <= (state_q == FR_IDLE) && is_par;
            if (emit) begin
                rec_opcode  <= op_q;
                rec_count   <= cnt_q;
                rec_params  <= par_q;
                rec_trunc   <= trunc_q;
                rec_unknown <= unk_q;
            end
            if (is_cmd) begin
                op_q    <= byte_data;
                cnt_q   <= '0;
                par_q   <= '0;
                trunc_q <= 1'b0;
                unk_q   <= !op_known(byte_data);
            end else if (is_par && state_q == FR_OPEN) begin
                if (cnt_q < CW'(MAX_PARAMS)) begin
                    for (int i = 0; i < MAX_PARAMS; i++)
                        if (cnt_q == CW'(i)) par_q[i*8 +: 8] <= byte_data;
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    trunc_q <= 1'b1;
                end
            end
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_count <= CW'(MAX_PARAMS)));
    a_r6_trunc_only_full: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_trunc) |-> (rec_count == CW'(MAX_PARAMS)));
    a_r5_emit_from_open: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(state_q == FR_OPEN));
    a_r8_orphan_from_idle: assert property (@(posedge clk) disable iff (rst)
        orphan_pulse |-> $past(state_q == FR_IDLE));
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

endmodule

// File: rtl/disp_spi_mon.sv
`timescale 1ns/1ps
module disp_spi_mon #(
    parameter int MAX_PARAMS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                spi_csn,
    input  logic                                spi_sck,
    input  logic                                spi_sdi,
    input  logic                                spi_dcx,
    output logic                                rec_valid,
    output logic [7:0]                          rec_opcode,
    output logic [$clog2(MAX_PARAMS+1)-1:0]     rec_count,
    output logic [MAX_PARAMS*8-1:0]             rec_params,
    output logic                                rec_trunc,
    output logic                                rec_unknown,
    output logic                                orphan_pulse
);

    logic [3:0] pins_sync;
    logic       b_valid, b_param, c_end;
    logic [7:0] b_data;

    dspim_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({spi_csn, spi_sck, spi_sdi, spi_dcx}),
        .d_sync  (pins_sync)
    );

    dspim_deser u_deser (
        .clk        (clk),
        .rst        (rst),
        .s_csn      (pins_sync[3]),
        .s_sck      (pins_sync[2]),
        .s_sdi      (pins_sync[1]),
        .s_dcx      (pins_sync[0]),
        .byte_valid (b_valid),
        .byte_data  (b_data),
        .byte_param (b_param),
        .cs_end     (c_end)
    );

    dspim_framer #(.MAX_PARAMS(MAX_PARAMS)) u_framer (
        .clk          (clk),
        .rst          (rst),
        .byte_valid   (b_valid),
        .byte_data    (b_data),
        .byte_param   (b_param),
        .cs_end       (c_end),
        .rec_valid    (rec_valid),
        .rec_opcode   (rec_opcode),
        .rec_count    (rec_count),
        .rec_params   (rec_params),
        .rec_trunc    (rec_trunc),
        .rec_unknown  (rec_unknown),
        .orphan_pulse (orphan_pulse)
    );

endmodule

// File: tb/test_disp_spi_mon.sv
`timescale 1ns/1ps
module test_disp_spi_mon;

    localparam int NV = 6;
    localparam logic [7:0] T_OP  [NV] = '{8'h2A, 8'h3A, 8'h55, 8'h00, 8'h2C, 8'hE1};
    localparam int         T_N   [NV] = '{4, 1, 2, 0, 18, 16};
    localparam bit         T_UNK [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    logic clk = 1'b0, rst = 1'b1;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0, spi_dcx = 1'b0;
    logic         rec_valid, rec_trunc, rec_unknown, orphan_pulse;
    logic [7:0]   rec_opcode;
    logic [4:0]   rec_count;
    logic [127:0] rec_params;

    int checks = 0, errors = 0;
    int nlog = 0, norphan = 0, ndouble = 0;
    logic prev_valid = 1'b0;
    logic [142:0] log_rec [64];

    always #4 clk = ~clk;

    disp_spi_mon i_disp_spi_mon (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .spi_dcx(spi_dcx), .rec_valid(rec_valid),
        .rec_opcode(rec_opcode), .rec_count(rec_count), .rec_params(rec_params),
        .rec_trunc(rec_trunc), .rec_unknown(rec_unknown), .orphan_pulse(orphan_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rec_valid && prev_valid) ndouble++;
            if (rec_valid && nlog < 64) begin
                log_rec[nlog] = {rec_opcode, rec_count, rec_trunc, rec_unknown, rec_params};
                nlog++;
            end
            if (orphan_pulse) norphan++;
        end
        prev_valid = rec_valid;
    end

    function automatic logic [142:0] pack(input logic [7:0] op, input int cnt,
                                          input bit tr, input bit unk, input logic [127:0] p);
        return {op, 5'(cnt), tr, unk, p};
    endfunction

    task automatic check(input string req, input logic [142:0] act, input logic [142:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, input logic dc);
        spi_dcx = dc;
        #40;
        for (int i = 7; i >= 0; i--) begin
            spi_sdi = b[i];
            #40 spi_sck = 1'b1;
            #40 spi_sck = 1'b0;
        end
        #40;
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        #80;
    endtask

    task automatic cs_high();
        #80 spi_csn = 1'b1;
        #240;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        logic [127:0] p;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", 143'(rec_valid), 143'(0));
        check("R10 reset record", {rec_opcode, rec_count, rec_trunc, rec_unknown, rec_params}, 143'(0));
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 reset orphan", 143'(orphan_pulse), 143'(0));

        // R3 R4 R5 R6 R7: table of records in one selection
        base = nlog;
        cs_low();
        for (int k = 0; k < NV; k++) begin
            spi_byte(T_OP[k], 1'b0);
            for (int i = 0; i < T_N[k]; i++) spi_byte(8'(k*32 + i + 1), 1'b1);
        end
        cs_high();
        check("R5 record count", 143'(nlog - base), 143'(NV));
        for (int k = 0; k < NV; k++) begin
            int n;
            n = (T_N[k] > 16) ? 16 : T_N[k];
            p = '0;
            for (int i = 0; i < n; i++) p[i*8 +: 8] = 8'(k*32 + i + 1);
            check($sformatf("R6 R7 table record %0d", k), log_rec[base + k],
                  pack(T_OP[k], n, T_N[k] > 16, T_UNK[k], p));
        end

        // R1: activity while deselected
        base = nlog;
        for (int i = 0; i < 11; i++) begin
            spi_sdi = i[0];
            #40 spi_sck = 1'b1;
            #40 spi_sck = 1'b0;
        end
        #200;
        check("R1 no record while deselected", 143'(nlog - base), 143'(0));
        cs_low();
        spi_byte(8'h2B, 1'b0);
        cs_high();
        check("R1 fresh byte after deselect", log_rec[base], pack(8'h2B, 0, 0, 0, '0));

        // R2: falling edge without capture ignored
        base = nlog;
        spi_sck = 1'b1;
        #80;
        spi_csn = 1'b0;
        #80 spi_sck = 1'b0;
        #80;
        spi_byte(8'h36, 1'b0);
        spi_byte(8'hA5, 1'b1);
        cs_high();
        check("R2 stray fall ignored", log_rec[base], pack(8'h36, 1, 0, 0, 128'hA5));

        // R9: partial byte discarded, open record emitted
        base = nlog;
        cs_low();
        spi_byte(8'h11, 1'b0);
        for (int i = 0; i < 3; i++) begin
            spi_sdi = 1'b1;
            #40 spi_sck = 1'b1;
            #40 spi_sck = 1'b0;
        end
        cs_high();
        check("R9 emit on deselect", log_rec[base], pack(8'h11, 0, 0, 0, '0));
        cs_low();
        spi_byte(8'h29, 1'b0);
        cs_high();
        check("R9 partial discarded", log_rec[base + 1], pack(8'h29, 0, 0, 0, '0));

        // R8: orphan parameter
        base = nlog;
        norphan = 0;
        cs_low();
        spi_byte(8'h77, 1'b1);
        #200;
        check("R8 orphan pulse", 143'(norphan), 143'(1));
        spi_byte(8'h01, 1'b0);
        spi_byte(8'h05, 1'b1);
        cs_high();
        check("R8 orphan dropped", log_rec[base], pack(8'h01, 1, 0, 0, 128'h05));

        // R10: reset with open record
        base = nlog;
        cs_low();
        spi_byte(8'h2A, 1'b0);
        spi_byte(8'h12, 1'b1);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cs_high();
        check("R10 open record cleared", 143'(nlog - base), 143'(0));

        // R11: strobe width
        check("R11 single cycle strobe", 143'(ndouble), 143'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule